// File: doc/BRIEF.md
# Dithered Coarse-Plus-Fine PWM Generator

This block drives one analog-control pin with a high-resolution pulse train. The setting is held as two halves. The coarse half sets the width of a pulse that repeats in every subperiod. The fine half decides in which subperiods one extra short pulse is added. After an RC filter, the output averages to a value with the resolution of both halves together. The comparator width is only that of one half.

A free-running counter advances once every `PRESCALE` system clocks. The low `COARSE_W` counter bits give the position within a subperiod. The high `FINE_W` counter bits give the subperiod index. Written values sit in holding registers. They are copied to the working setting only when the counter wraps, so every full cycle uses one consistent setting. A polarity input can invert the pulse train. A pin-enable input chooses between the pulse train and a plain port data bit.

Top module: `dither_pwm`

## Requirements
- R1: The counter advances once every `PRESCALE` clocks. A subperiod lasts 2^`COARSE_W` counts. A full cycle lasts 2^`FINE_W` subperiods.
- R2: The coarse pulse is low at positions 0 to the coarse value and high from that value + 1 up to the last position of each subperiod.
- R3: A fine pulse lasts one count, at position 0 of subperiod k (k ≠ 0). It is present when fine bit [`FINE_W`-1-tz(k)] is 0, where tz(k) is the number of trailing zero bits of k. Subperiod 0 never gets a fine pulse.
- R4: When several fine bits are 0, the union of their subperiod sets gets fine pulses.
- R5: A fine value of all ones adds no fine pulses, so the output is the coarse pulse alone.
- R6: The pulse train is the OR of the coarse pulse and the fine pulses.
- R7: When `pol_i` = 1 the pulse train is inverted on the pin.
- R8: When `pin_en_i` = 0 the pin carries `port_d_i`, and the pulse train has no effect on it.
- R9: A write to either half takes effect only from position 0 of subperiod 0 of the next cycle. At that point both halves are loaded together, and a half that was not written keeps its earlier value.
- R10: Reset clears both halves, the counter and the prescaler. The enabled pin then sits at its inactive level, which equals `pol_i`.
- R11: A coarse value of all ones gives no coarse pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hi_we_i | input | 1 | Write strobe for the coarse half |
| hi_d_i | input | COARSE_W | Coarse half write data |
| lo_we_i | input | 1 | Write strobe for the fine half |
| lo_d_i | input | FINE_W | Fine half write data |
| pol_i | input | 1 | 1 inverts the pulse train |
| pin_en_i | input | 1 | 1 selects the pulse train, 0 selects port data |
| port_d_i | input | 1 | Plain port data bit |
| pin_o | output | 1 | Output pin |

## Verification
The bench builds the block with `COARSE_W` = 4, `FINE_W` = 3 and `PRESCALE` = 3. This gives 16-count subperiods, 8 subperiods per cycle and a full cycle of 384 clocks. With this setting, every fine-bit selection set can be checked pin-exact over whole cycles. This covers the single midpoint subperiod, the quarter points, all odd subperiods and their unions. It also covers deferred loading across a cycle wrap and a write to only one half. Both coarse extremes are checked, and so are the polarity and port-data paths.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  // index of least significant set bit, 0 when none
  function automatic int unsigned lowest_set(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--)
      if (v[i]) r = i;
    return r;
  endfunction
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int PRESCALE = 3,
  parameter int CNT_W    = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             tick_o,
  output logic             wrap_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  generate
    if (PRESCALE > 1) begin : g_div
      localparam int PS_W = $clog2(PRESCALE);
      localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);
      logic [PS_W-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              div_q <= '0;
        else if (div_q == PS_LAST) div_q <= '0;
        else                       div_q <= div_q + 1'b1;
      end
      assign tick_o = (div_q == PS_LAST);

      // R1
      tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end else begin : g_nodiv
      assign tick_o = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_o & (&cnt_q);

  // R1
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(cnt_o));
  // R1
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));
endmodule

// File: rtl/pwm_setting_regs.sv
module pwm_setting_regs #(
  parameter int HI_W = 7,
  parameter int LO_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hi_we_i,
  input  logic [HI_W-1:0] hi_d_i,
  input  logic            lo_we_i,
  input  logic [LO_W-1:0] lo_d_i,
  input  logic            load_i,
  output logic [HI_W-1:0] work_hi_o,
  output logic [LO_W-1:0] work_lo_o
);
  logic [HI_W-1:0] hold_hi_q, work_hi_q;
  logic [LO_W-1:0] hold_lo_q, work_lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_hi_q <= '0;
      hold_lo_q <= '0;
    end else begin
      if (hi_we_i) hold_hi_q <= hi_d_i;
      if (lo_we_i) hold_lo_q <= lo_d_i;
    end
  end

  // both halves move together, only at cycle wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_hi_q <= '0;
      work_lo_q <= '0;
    end else if (load_i) begin
      work_hi_q <= hold_hi_q;
      work_lo_q <= hold_lo_q;
    end
  end

  assign work_hi_o = work_hi_q;
  assign work_lo_o = work_lo_q;

  // R9
  work_defer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(work_hi_o) && $stable(work_lo_o)));
endmodule

// File: rtl/pwm_pulse_gen.sv
module pwm_pulse_gen
  import dpwm_pkg::*;
#(
  parameter int POS_W = 7,
  parameter int SUB_W = 7
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [POS_W+SUB_W-1:0] cnt_i,
  input  logic [POS_W-1:0]       hi_i,
  input  logic [SUB_W-1:0]       lo_i,
  output logic                   raw_o
);
  localparam int CNT_W = POS_W + SUB_W;

  logic [POS_W-1:0] pos;
  logic [SUB_W-1:0] sub;
  logic             coarse, fine;
  int unsigned      lsb;

  assign pos    = cnt_i[POS_W-1:0];
  assign sub    = cnt_i[CNT_W-1:POS_W];
  assign coarse = (pos > hi_i);
  assign lsb    = lowest_set(32'(sub));

  // subperiod k picks fine bit SUB_W-1-tz(k)
  always_comb begin
    fine = 1'b0;
    if (pos == '0 && sub != '0)
      for (int j = 0; j < SUB_W; j++)
        if (lsb == 32'(j)) fine = ~lo_i[SUB_W-1-j];
  end

  assign raw_o = coarse | fine;

  // R3
  sub0_start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos == '0 && raw_o) |-> sub != '0);
  // R5
  fine_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&lo_i) && pos == '0) |-> !raw_o);
endmodule

// File: rtl/dither_pwm.sv
module dither_pwm #(
  parameter int COARSE_W = 7,
  parameter int FINE_W   = 7,
  parameter int PRESCALE = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hi_we_i,
  input  logic [COARSE_W-1:0] hi_d_i,
  input  logic                lo_we_i,
  input  logic [FINE_W-1:0]   lo_d_i,
  input  logic                pol_i,
  input  logic                pin_en_i,
  input  logic                port_d_i,
  output logic                pin_o
);
  localparam int CNT_W = COARSE_W + FINE_W;

  logic                tick, wrap, raw;
  logic [CNT_W-1:0]    cnt;
  logic [COARSE_W-1:0] work_hi;
  logic [FINE_W-1:0]   work_lo;

  pwm_timebase #(.PRESCALE(PRESCALE), .CNT_W(CNT_W)) u_tb (
    .clk_i, .rst_ni, .tick_o(tick), .wrap_o(wrap), .cnt_o(cnt)
  );

  pwm_setting_regs #(.HI_W(COARSE_W), .LO_W(FINE_W)) u_regs (
    .clk_i, .rst_ni, .hi_we_i, .hi_d_i, .lo_we_i, .lo_d_i,
    .load_i(wrap), .work_hi_o(work_hi), .work_lo_o(work_lo)
  );

  pwm_pulse_gen #(.POS_W(COARSE_W), .SUB_W(FINE_W)) u_gen (
    .clk_i, .rst_ni, .cnt_i(cnt), .hi_i(work_hi), .lo_i(work_lo), .raw_o(raw)
  );

  assign pin_o = pin_en_i ? (raw ^ pol_i) : port_d_i;

  // R11
  stuck_inactive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&work_hi) && (&work_lo) && pin_en_i) |-> pin_o == pol_i);
endmodule

// File: tb/dither_pwm_test.sv
`timescale 1ns/1ps
module dither_pwm_test;
  localparam int CW  = 4;
  localparam int FW  = 3;
  localparam int PS  = 3;
  localparam int POS = 1 << CW;
  localparam int NSUB = 1 << FW;
  localparam int CYC = PS * POS * NSUB;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          hi_we = 1'b0, lo_we = 1'b0;
  logic [CW-1:0] hi_d = '0;
  logic [FW-1:0] lo_d = '0;
  logic          pol = 1'b0, pin_en = 1'b1, port_d = 1'b0;
  logic          pin;

  int tests = 0, fails = 0;
  int edge_cnt;
  logic [CW-1:0] ph, eh;
  logic [FW-1:0] pl, el;

  always #2 clk = ~clk;

  dither_pwm #(.COARSE_W(CW), .FINE_W(FW), .PRESCALE(PS)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .hi_we_i(hi_we), .hi_d_i(hi_d),
    .lo_we_i(lo_we), .lo_d_i(lo_d), .pol_i(pol), .pin_en_i(pin_en),
    .port_d_i(port_d), .pin_o(pin)
  );

  // expected settings: written values become effective at each cycle wrap (R9)
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_cnt <= 0; ph <= '0; pl <= '0; eh <= '0; el <= '0;
    end else begin
      edge_cnt <= edge_cnt + 1;
      if (hi_we) ph <= hi_d;
      if (lo_we) pl <= lo_d;
      if ((edge_cnt + 1) % CYC == 0) begin
        eh <= ph; el <= pl;
      end
    end
  end

  function automatic logic model(int e);
    int c, t, k, tz;
    logic co, fi;
    c  = (e / PS) % (POS * NSUB);
    t  = c % POS;
    k  = c / POS;
    co = (t > int'(eh));
    fi = 1'b0;
    if (t == 0 && k != 0) begin
      tz = 0;
      while (((k >> tz) & 1) == 0) tz++;
      fi = !el[FW-1-tz];
    end
    return pin_en ? ((co | fi) ^ pol) : port_d;
  endfunction

  task automatic run_span(int n, string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      logic exp;
      @(negedge clk);
      port_d = (i % 5) < 2;
      #1;
      exp = model(edge_cnt);
      if (pin !== exp) begin
        if (bad == 0)
          $display("FAIL %s: edge %0d pin=%b expected %b", tag, edge_cnt, pin, exp);
        bad++;
      end
    end
    tests++;
    if (bad != 0) fails++;
  endtask

  task automatic wr_hi(logic [CW-1:0] v);
    hi_d = v; hi_we = 1'b1;
    @(negedge clk);
    hi_we = 1'b0;
  endtask

  task automatic wr_lo(logic [FW-1:0] v);
    lo_d = v; lo_we = 1'b1;
    @(negedge clk);
    lo_we = 1'b0;
  endtask

  task automatic wait_boundary();
    while (edge_cnt % CYC != 0) @(negedge clk);
  endtask

  task automatic scen(logic [CW-1:0] h, logic [FW-1:0] l, string tag);
    wr_hi(h);
    wr_lo(l);
    wait_boundary();
    run_span(CYC, tag);
  endtask

  task automatic t_reset();
    #1;
    tests++;
    if (pin !== 1'b0) begin
      fails++;
      $display("FAIL R10: pin=%b expected 0 in reset, pol=0", pin);
    end
    pol = 1'b1;
    #1;
    tests++;
    if (pin !== 1'b1) begin
      fails++;
      $display("FAIL R10: pin=%b expected 1 in reset, pol=1", pin);
    end
    pol = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    // first cycle after reset runs with cleared halves
    run_span(CYC, "R10 R1 cleared");
  endtask

  task automatic t_defer();
    wr_hi(4'd6);
    wr_lo(3'b111);
    wait_boundary();
    run_span(100, "R9 old setting");
    wr_lo(3'b101);
    run_span(CYC - 101, "R9 before wrap");
    run_span(CYC, "R9 both halves loaded");
  endtask

  initial begin
    t_reset();
    scen(4'd5,  3'b111, "R2 R5 R1 coarse only");
    scen(4'd0,  3'b111, "R2 widest coarse");
    scen(4'd15, 3'b111, "R11 no coarse");
    scen(4'd15, 3'b110, "R3 midpoint subperiod");
    scen(4'd15, 3'b101, "R3 quarter subperiods");
    scen(4'd15, 3'b011, "R3 odd subperiods");
    scen(4'd15, 3'b000, "R4 all but subperiod 0");
    scen(4'd9,  3'b010, "R4 R6 union with coarse");
    pol = 1'b1;
    scen(4'd3,  3'b100, "R7 inverted");
    pol = 1'b0;
    pin_en = 1'b0;
    scen(4'd2,  3'b000, "R8 port data");
    pin_en = 1'b1;
    t_defer();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule